// File: doc/BRIEF.md
# Dead-Band PWM Generator

This block combines a down-counting PWM with a dead-band stage. It produces two complementary drive phases, a primary and an auxiliary, for a half-bridge style load. An 8-bit down counter reloads from the period value each time it reaches zero, and that zero is flagged as terminal count. An internal PWM level is high while the count is above the compare value. The primary phase follows the high part of that level and the auxiliary phase follows the low part. Each phase is switched on only after a dead time chosen from four widths, and it is switched off at once. As a result the two phases never overlap.

Two running modes exist, and there is no gate input. Free-running mode counts for as long as the block is enabled. Pulse-generator mode emits a programmed number of periods and then pauses the counter, but the block stays enabled. A hardware start level or a software start strobe resumes counting after the pause. If the hardware start is already high when the final period ends, counting carries on without a pause.

Top module: `dbpwm_top`

## Requirements
- R1: While reset is high, or while `en` is low, `out_pri`, `out_aux`, `tc` and `busy` are all 0.
- R2: When `en` rises, the counter loads `period` and `busy` goes high on the next clock. Both phases are 0 in that first running cycle.
- R3: While running, `tc` is a one-cycle pulse at count zero. Consecutive pulses are `period`+1 cycles apart.
- R4: The dead time is `len` = 1 << `db_sel` clocks, so `db_sel` 0, 1, 2 and 3 give 1, 2, 4 and 8. In steady state `out_pri` is high for `period`-`compare`-`len` cycles and `out_aux` is high for `compare`+1-`len` cycles per period.
- R5: After either phase falls, both phases stay low for exactly `len` cycles before the other phase rises. The two phases are never high together.
- R6: If a PWM half-period is `len` cycles or shorter, the phase belonging to that half stays low.
- R7: With `mode`=0 (free-running), or with `mode`=1 and `shot_count`=0, the counter runs without stopping.
- R8: With `mode`=1 and `shot_count`=N>0, exactly N `tc` pulses occur and then `busy` falls. While stopped, `tc`, `out_pri` and `out_aux` stay 0 and the block remains enabled.
- R9: While stopped, a high `hw_start` level or a one-cycle `sw_start` strobe restarts counting for another N periods.
- R10: If `hw_start` is high when the last period ends, counting continues without a pause. A start input asserted while the counter is running does not change the `tc` spacing.
- R11: When `en` goes low, all outputs are 0 from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable level; a rising edge starts the block |
| sw_start | input | 1 | One-cycle software start strobe; takes effect while stopped |
| hw_start | input | 1 | Hardware start level |
| mode | input | 1 | 0 = free-running, 1 = pulse-generator |
| period | input | 8 | Counter reload value |
| compare | input | 8 | PWM level is high while count > compare |
| db_sel | input | 2 | Dead-time select, len = 1 << db_sel |
| shot_count | input | 8 | Periods per burst in pulse-generator mode; 0 = unlimited |
| out_pri | output | 1 | Primary phase |
| out_aux | output | 1 | Auxiliary phase |
| tc | output | 1 | Terminal count pulse |
| busy | output | 1 | Counter running |

## Verification
The PWM path is exercised with several period, compare and dead-time combinations. Some give two visible phases of different widths. One has a primary pulse shorter than the dead time, and one has an auxiliary pulse shorter than it. This separates errors in the width arithmetic from errors in the suppression of short pulses. The burst mode is run in four ways: with no restart, restarted by the hardware level, restarted by the software strobe, and with the hardware start held across the last period. This tells a correct stop apart from an early or missing stop and from a restart that reloads the wrong count. A start strobe in the middle of a period confirms that the tc spacing is unchanged while the counter runs.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;

    localparam int CNT_W = 8;
    localparam int SEL_W = 2;
    localparam int DT_W  = (1 << SEL_W);
    localparam int N_PH  = 2;

    typedef enum logic {
        RUN_FREE = 1'b0,
        RUN_PPG  = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic tc;
        logic pwm_hi;
    } cnt_stat_t;

    typedef struct packed {
        logic running;
        logic start_now;
    } ctl_stat_t;

    function automatic logic [DT_W-1:0] dead_len(input logic [SEL_W-1:0] sel);
        return DT_W'(1) << sel;
    endfunction

endpackage

// File: rtl/dbpwm_counter.sv
module dbpwm_counter
    import dbpwm_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] period,
    input  logic [W-1:0] compare,
    output cnt_stat_t    st
);

    logic [W-1:0] cnt;
    logic         at_zero;

    assign at_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= period;
        end else if (run) begin
            cnt <= at_zero ? period : cnt - W'(1);
        end
    end

    always_comb begin
        st.tc     = run && at_zero;
        st.pwm_hi = run && (cnt > compare);
    end

endmodule

// File: rtl/dbpwm_shotctl.sv
module dbpwm_shotctl
    import dbpwm_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sw_start,
    input  logic         hw_start,
    input  run_mode_e    mode,
    input  logic [W-1:0] shot_count,
    input  logic         tc,
    output ctl_stat_t    st
);

    logic         en_q;
    logic         running;
    logic [W-1:0] shots_left;
    logic         en_rise;
    logic         restart;
    logic         counted;
    logic         final_shot;

    assign en_rise    = en && !en_q;
    assign restart    = en && en_q && !running && (sw_start || hw_start);
    assign counted    = (mode == RUN_PPG) && (shot_count != '0);
    assign final_shot = tc && counted && (shots_left <= W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            running    <= 1'b0;
            shots_left <= '0;
        end else begin
            en_q <= en;
            if (!en) begin
                running <= 1'b0;
            end else if (en_rise || restart) begin
                running    <= 1'b1;
                shots_left <= shot_count;
            end else if (final_shot) begin
                if (hw_start) begin
                    shots_left <= shot_count;
                end else begin
                    running <= 1'b0;
                end
            end else if (tc && counted) begin
                shots_left <= shots_left - W'(1);
            end
        end
    end

    always_comb begin
        st.running   = running;
        st.start_now = en_rise || restart;
    end

endmodule

// File: rtl/dbpwm_phase.sv
module dbpwm_phase
    import dbpwm_pkg::*;
#(
    parameter int DW = DT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          want,
    input  logic [DW-1:0] len,
    output logic          out
);

    logic          lvl_q;
    logic [DW-1:0] held;

    always_ff @(posedge clk) begin
        if (rst || clr || !want) begin
            lvl_q <= 1'b0;
            held  <= '0;
        end else if (!lvl_q) begin
            lvl_q <= 1'b1;
            held  <= '0;
        end else if (held < len) begin
            held <= held + DW'(1);
        end
    end

    assign out = lvl_q && (held >= len);

endmodule

// File: rtl/dbpwm_top.sv
module dbpwm_top
    import dbpwm_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sw_start,
    input  logic          hw_start,
    input  logic          mode,
    input  logic [W-1:0]  period,
    input  logic [W-1:0]  compare,
    input  logic [SW-1:0] db_sel,
    input  logic [W-1:0]  shot_count,
    output logic          out_pri,
    output logic          out_aux,
    output logic          tc,
    output logic          busy
);

    localparam int DW = (1 << SW);

    cnt_stat_t       cst;
    ctl_stat_t       kst;
    logic            armed;
    logic [N_PH-1:0] want;
    logic [N_PH-1:0] ph_out;
    logic [DW-1:0]   len;

    assign len = DW'(1) << db_sel;

    dbpwm_shotctl #(.W(W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .sw_start   (sw_start),
        .hw_start   (hw_start),
        .mode       (run_mode_e'(mode)),
        .shot_count (shot_count),
        .tc         (cst.tc),
        .st         (kst)
    );

    dbpwm_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (!en || kst.start_now),
        .run     (kst.running),
        .period  (period),
        .compare (compare),
        .st      (cst)
    );

    always_ff @(posedge clk) begin
        if (rst || !en || !kst.running) begin
            armed <= 1'b0;
        end else if (cst.pwm_hi) begin
            armed <= 1'b1;
        end
    end

    assign want[0] = cst.pwm_hi;
    assign want[1] = kst.running && armed && !cst.pwm_hi;

    for (genvar g = 0; g < N_PH; g++) begin : g_phase
        dbpwm_phase #(.DW(DW)) u_ph (
            .clk  (clk),
            .rst  (rst),
            .clr  (!en),
            .want (want[g]),
            .len  (len),
            .out  (ph_out[g])
        );
    end

    assign out_pri = ph_out[0];
    assign out_aux = ph_out[1];
    assign tc      = cst.tc;
    assign busy    = kst.running;

endmodule

// File: rtl/dbpwm_chk.sv
module dbpwm_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic busy,
    input logic tc,
    input logic pri,
    input logic aux
);

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(pri && aux));

    // R11
    disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pri && !aux && !busy));

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!pri && !aux));

    // R8
    stopped_no_tc_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tc);

    // R8
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> (!pri && !aux));

endmodule

bind dbpwm_top dbpwm_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .busy (busy),
    .tc   (tc),
    .pri  (out_pri),
    .aux  (out_aux)
);

// File: tb/sim_dbpwm_top.sv
`timescale 1ns/1ps
module sim_dbpwm_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, sw_start = 1'b0, hw_start = 1'b0, mode = 1'b0;
    logic [7:0] period = 8'd20, compare = 8'd9, shot_count = 8'd0;
    logic [1:0] db_sel = 2'd0;
    logic       out_pri, out_aux, tc, busy;
    int         n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    dbpwm_top u0 (
        .clk(clk), .rst(rst), .en(en), .sw_start(sw_start), .hw_start(hw_start),
        .mode(mode), .period(period), .compare(compare), .db_sel(db_sel),
        .shot_count(shot_count), .out_pri(out_pri), .out_aux(out_aux),
        .tc(tc), .busy(busy)
    );

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic pick(input bit aux_sel);
        return aux_sel ? out_aux : out_pri;
    endfunction

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tc_gap(output int gap);
        gap = 0;
        for (int i = 0; i < 1000 && !tc; i++) @(negedge clk);
        @(negedge clk);
        gap = 1;
        for (int i = 0; i < 1000 && !tc; i++) begin
            @(negedge clk);
            gap++;
        end
    endtask

    task automatic high_width(input bit aux_sel, output int w);
        w = 0;
        for (int i = 0; i < 1000 && pick(aux_sel); i++) @(negedge clk);
        for (int i = 0; i < 1000 && !pick(aux_sel); i++) @(negedge clk);
        for (int i = 0; i < 1000 && pick(aux_sel); i++) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic dead_gap(output int g);
        g = 0;
        for (int i = 0; i < 1000 && !out_pri; i++) @(negedge clk);
        for (int i = 0; i < 1000 && out_pri; i++) @(negedge clk);
        for (int i = 0; i < 1000 && !out_aux && !out_pri; i++) begin
            g++;
            @(negedge clk);
        end
    endtask

    task automatic count_high(input int n, output int pri_hits, output int aux_hits);
        pri_hits = 0;
        aux_hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_pri) pri_hits++;
            if (out_aux) aux_hits++;
        end
    endtask

    task automatic shots_until_stop(output int n);
        n = 0;
        for (int i = 0; i < 3000 && busy; i++) begin
            if (tc) n++;
            @(negedge clk);
        end
    endtask

    task automatic setup(input logic [7:0] p, input logic [7:0] c, input logic [1:0] s,
                         input logic m, input logic [7:0] sh);
        en = 1'b0;
        @(negedge clk);
        period = p; compare = c; db_sel = s; mode = m; shot_count = sh;
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(int'({out_pri, out_aux, tc, busy}), 0, "R1 reset outputs");
        rst = 1'b0;
        cyc(3);
        check(int'({out_pri, out_aux, tc, busy}), 0, "R1 disabled outputs");
    endtask

    task automatic t_enable();
        setup(8'd20, 8'd9, 2'd1, 1'b0, 8'd0);
        check(int'({busy, out_pri, out_aux}), 3'b100, "R2 first running cycle");
    endtask

    task automatic t_pwm(input logic [7:0] p, input logic [7:0] c, input logic [1:0] s);
        int gap, wp, wa, dg, len;
        len = 1 << s;
        setup(p, c, s, 1'b0, 8'd0);
        tc_gap(gap);
        check(gap, p + 1, "R3 tc spacing");
        high_width(1'b0, wp);
        check(wp, p - c - len, "R4 primary width");
        high_width(1'b1, wa);
        check(wa, c + 1 - len, "R4 auxiliary width");
        dead_gap(dg);
        check(dg, len, "R5 dead gap");
    endtask

    task automatic t_short(input logic [7:0] p, input logic [7:0] c, input logic [1:0] s,
                           input bit aux_short);
        int hp, ha;
        setup(p, c, s, 1'b0, 8'd0);
        count_high(6 * (p + 1), hp, ha);
        if (aux_short) begin
            check(ha, 0, "R6 short auxiliary held low");
            check(int'(hp > 0), 1, "R6 primary still active");
        end else begin
            check(hp, 0, "R6 short primary held low");
            check(int'(ha > 0), 1, "R6 auxiliary still active");
        end
    endtask

    task automatic t_free_zero_shots();
        int gap;
        setup(8'd10, 8'd4, 2'd0, 1'b1, 8'd0);
        cyc(80);
        check(int'(busy), 1, "R7 zero shots keeps running");
        tc_gap(gap);
        check(gap, 11, "R7 spacing with zero shots");
    endtask

    task automatic t_ppg();
        int n, hp, ha, tcs;
        setup(8'd10, 8'd4, 2'd0, 1'b1, 8'd3);
        shots_until_stop(n);
        check(n, 3, "R8 burst length");
        tcs = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (tc || busy) tcs++;
        end
        check(tcs, 0, "R8 stays stopped");
        count_high(20, hp, ha);
        check(hp + ha, 0, "R8 phases low while stopped");
        hw_start = 1'b1;
        @(negedge clk);
        hw_start = 1'b0;
        check(int'(busy), 1, "R9 hardware restart");
        shots_until_stop(n);
        check(n, 3, "R9 burst after hardware restart");
        cyc(10);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        check(int'(busy), 1, "R9 software restart");
        shots_until_stop(n);
        check(n, 3, "R9 burst after software restart");
    endtask

    task automatic t_hold_start();
        int n, gap;
        setup(8'd10, 8'd4, 2'd0, 1'b1, 8'd2);
        hw_start = 1'b1;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            if (tc) n++;
            @(negedge clk);
        end
        check(int'(busy), 1, "R10 held start continues");
        check(int'(n > 2), 1, "R10 more periods than burst");
        tc_gap(gap);
        check(gap, 11, "R10 held start spacing");
        hw_start = 1'b0;
        shots_until_stop(n);
        check(int'(busy), 0, "R8 stops after start released");
        setup(8'd12, 8'd5, 2'd0, 1'b0, 8'd0);
        for (int i = 0; i < 100 && !tc; i++) @(negedge clk);
        cyc(4);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        gap = 5;
        for (int i = 0; i < 100 && !tc; i++) begin
            @(negedge clk);
            gap++;
        end
        check(gap, 13, "R10 strobe while running");
    endtask

    task automatic t_disable();
        setup(8'd20, 8'd9, 2'd0, 1'b0, 8'd0);
        for (int i = 0; i < 100 && !out_pri; i++) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(int'({out_pri, out_aux, tc, busy}), 0, "R11 disable clears outputs");
        cyc(30);
        check(int'({out_pri, out_aux, tc, busy}), 0, "R1 stays idle while disabled");
    endtask

    initial begin
        cyc(4);
        t_reset();
        t_enable();
        t_pwm(8'd20, 8'd9, 2'd1);
        t_pwm(8'd40, 8'd20, 2'd2);
        t_pwm(8'd30, 8'd10, 2'd0);
        t_short(8'd20, 8'd17, 2'd2, 1'b0);
        t_short(8'd15, 8'd3, 2'd3, 1'b1);
        t_free_zero_shots();
        t_ppg();
        t_hold_start();
        t_disable();
        finish_run();
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule